// File: doc/BRIEF.md
# Machine-Mode Control Register File with 64-bit Counters

This block keeps the machine-level control state of a small 32-bit core: status word, interrupt enables, trap base, scratch word, trap return address, trap cause, a pending-interrupt word merged with three live request lines, and two 64-bit event counters (clock cycles and retired instructions). Each counter is reached as two 32-bit halves, and an inhibit word can freeze either one. A set of constant identification words is also readable.

The core presents a 12-bit register address, a read strobe, a write strobe with a two-bit operation (plain write, bit set, bit clear), write data and its current privilege level. Read data and an illegal-access flag come back combinationally in the same cycle. A legal write is committed at the next rising clock edge. Both counters advance on every clock unless inhibited. When software writes one half of a counter in the same cycle, that half takes the written value and the other half takes the incremented count, including any carry.

Top module: `mcsr_file`

## Requirements
- R1: An access (read or write strobe high) whose address bits [9:8] are numerically greater than the privilege input (0 user, 1 supervisor, 3 machine) raises `csr_illegal`, returns zero read data and changes no register.
- R2: An access to an address that does not decode to an implemented register raises `csr_illegal` and returns zero read data. Implemented addresses: status 0x300, ISA word 0x301, enables 0x304, trap base 0x305, counter inhibit 0x320, scratch 0x340, return address 0x341, cause 0x342, trap value 0x343, pending 0x344, cycle low/high 0xB00/0xB80, retired low/high 0xB02/0xB82, vendor 0xF11, architecture 0xF12, implementation 0xF13, hart 0xF14, configuration pointer 0xF15.
- R3: A legal write with `csr_op` 2'b00 (or the unused code 2'b11) stores `csr_wdata`, after masking, at the next rising edge. Read data for a legal address shows the current value in the same cycle.
- R4: `csr_op` 2'b01 stores old OR data and 2'b10 stores old AND NOT data, where old is the value the register reads back in that cycle.
- R5: Write masks: trap base forces bit 1 to zero, return address forces bit 0 to zero, cause keeps only bit 31 and bits 3:0, counter inhibit keeps only bits 2:0.
- R6: Both 64-bit counters increment by one per clock with carry from the low half into the high half.
- R7: Inhibit bit 0 freezes the cycle counter and inhibit bit 2 freezes the retired counter. A write to the inhibit word takes effect on counting from the following cycle.
- R8: A write to one counter half in a cycle sets that half to the written value; the other half takes the incremented value of the full 64-bit count.
- R9: The pending word reads as its stored value ORed with the software line at bit 3, the timer line at bit 7 and the external line at bit 11.
- R10: The trap value and hart identifier read zero; vendor, architecture, implementation, ISA and configuration pointer words read their parameter values. Writes to any of these are legal and have no effect.
- R11: After reset, status, enables, trap base, scratch, return address, cause, pending, inhibit and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_ren | input | 1 | Read strobe |
| csr_wen | input | 1 | Write strobe |
| csr_op | input | 2 | 00 write, 01 set bits, 10 clear bits, 11 write |
| csr_wdata | input | 32 | Write data or bit mask |
| priv | input | 2 | Current privilege level |
| irq_soft | input | 1 | Software interrupt request line |
| irq_timer | input | 1 | Timer interrupt request line |
| irq_ext | input | 1 | External interrupt request line |
| csr_rdata | output | 32 | Read data, zero when the access is not legal |
| csr_illegal | output | 1 | Access faulted on privilege or decode |

## Verification
The assertions watch, on every cycle, the privilege fault, the per-clock advance and freeze of the counters, carry into the high cycle half while the low half is being written, the zero trap value, the cause read mask and the timer line appearing in the pending word. Only the bench scenarios, compared against a behavioural model each clock, can show the set and clear read-modify-write results, the other write masks, the undecoded-address fault, writes to identification words having no effect, and the exact one-cycle lag of an inhibit write.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

   localparam int ADDR_W = 12;

   localparam logic [ADDR_W-1:0] A_STATUS  = 12'h300;
   localparam logic [ADDR_W-1:0] A_ISA     = 12'h301;
   localparam logic [ADDR_W-1:0] A_IEN     = 12'h304;
   localparam logic [ADDR_W-1:0] A_TBASE   = 12'h305;
   localparam logic [ADDR_W-1:0] A_INHIBIT = 12'h320;
   localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
   localparam logic [ADDR_W-1:0] A_RETADDR = 12'h341;
   localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h342;
   localparam logic [ADDR_W-1:0] A_TVALUE  = 12'h343;
   localparam logic [ADDR_W-1:0] A_PEND    = 12'h344;
   localparam logic [ADDR_W-1:0] A_CYC_LO  = 12'hB00;
   localparam logic [ADDR_W-1:0] A_RET_LO  = 12'hB02;
   localparam logic [ADDR_W-1:0] A_CYC_HI  = 12'hB80;
   localparam logic [ADDR_W-1:0] A_RET_HI  = 12'hB82;
   localparam logic [ADDR_W-1:0] A_VENDOR  = 12'hF11;
   localparam logic [ADDR_W-1:0] A_ARCH    = 12'hF12;
   localparam logic [ADDR_W-1:0] A_IMPL    = 12'hF13;
   localparam logic [ADDR_W-1:0] A_HART    = 12'hF14;
   localparam logic [ADDR_W-1:0] A_CFGPTR  = 12'hF15;

   localparam int SOFT_LINE_BIT  = 3;
   localparam int TIMER_LINE_BIT = 7;
   localparam int EXT_LINE_BIT   = 11;

   localparam int CYC_FREEZE_BIT = 0;
   localparam int RET_FREEZE_BIT = 2;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b00,
      OP_SET   = 2'b01,
      OP_CLEAR = 2'b10,
      OP_ALT   = 2'b11
   } op_e;

   typedef enum logic [4:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_ISA,
      SEL_IEN,
      SEL_TBASE,
      SEL_INHIBIT,
      SEL_SCRATCH,
      SEL_RETADDR,
      SEL_CAUSE,
      SEL_TVALUE,
      SEL_PEND,
      SEL_CYC_LO,
      SEL_CYC_HI,
      SEL_RET_LO,
      SEL_RET_HI,
      SEL_VENDOR,
      SEL_ARCH,
      SEL_IMPL,
      SEL_HART,
      SEL_CFGPTR
   } sel_e;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
   import mcsr_pkg::*;
#(
   parameter int PRIV_W = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PRIV_W-1:0] priv,
   output sel_e              sel,
   output logic              hit,
   output logic              priv_fault
);

   localparam int LVL_LSB = 8;

   generate
      if (PRIV_W != 2) begin : g_bad_priv
         $error("mcsr_decode: privilege field must be 2 bits");
      end
   endgenerate

   always_comb begin
      unique case (addr)
         A_STATUS:  sel = SEL_STATUS;
         A_ISA:     sel = SEL_ISA;
         A_IEN:     sel = SEL_IEN;
         A_TBASE:   sel = SEL_TBASE;
         A_INHIBIT: sel = SEL_INHIBIT;
         A_SCRATCH: sel = SEL_SCRATCH;
         A_RETADDR: sel = SEL_RETADDR;
         A_CAUSE:   sel = SEL_CAUSE;
         A_TVALUE:  sel = SEL_TVALUE;
         A_PEND:    sel = SEL_PEND;
         A_CYC_LO:  sel = SEL_CYC_LO;
         A_CYC_HI:  sel = SEL_CYC_HI;
         A_RET_LO:  sel = SEL_RET_LO;
         A_RET_HI:  sel = SEL_RET_HI;
         A_VENDOR:  sel = SEL_VENDOR;
         A_ARCH:    sel = SEL_ARCH;
         A_IMPL:    sel = SEL_IMPL;
         A_HART:    sel = SEL_HART;
         A_CFGPTR:  sel = SEL_CFGPTR;
         default:   sel = SEL_NONE;
      endcase
   end

   assign hit        = (sel != SEL_NONE);
   assign priv_fault = (addr[LVL_LSB +: PRIV_W] > priv);

endmodule

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
   parameter int HALF_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inc,
   input  logic                  wr_lo,
   input  logic                  wr_hi,
   input  logic [HALF_W-1:0]     wdata,
   output logic [2*HALF_W-1:0]   count
);

   localparam int FULL_W = 2 * HALF_W;

   generate
      if (HALF_W < 1) begin : g_bad_width
         $error("mcsr_counter: half width must be positive");
      end
   endgenerate

   logic [FULL_W-1:0] stepped;

   assign stepped = count + FULL_W'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count[HALF_W-1:0]      <= wr_lo ? wdata : stepped[HALF_W-1:0];
         count[FULL_W-1:HALF_W] <= wr_hi ? wdata : stepped[FULL_W-1:HALF_W];
      end
   end

endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
   import mcsr_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          CAUSE_CODE_W = 4,
   parameter int          INHIBIT_W    = 3,
   parameter logic [31:0] VENDOR_WORD  = 32'h0000_0A5C,
   parameter logic [31:0] ARCH_WORD    = 32'h0000_0031,
   parameter logic [31:0] IMPL_WORD    = 32'h0102_0304,
   parameter logic [31:0] ISA_WORD     = 32'h4010_1105,
   parameter logic [31:0] CFGPTR_WORD  = 32'h0000_8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_ren,
   input  logic              csr_wen,
   input  logic [1:0]        csr_op,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic [1:0]        priv,
   input  logic              irq_soft,
   input  logic              irq_timer,
   input  logic              irq_ext,
   output logic [XLEN-1:0]   csr_rdata,
   output logic              csr_illegal
);

   localparam int CNT_W   = 2 * XLEN;
   localparam int N_CNT   = 2;
   localparam logic [XLEN-1:0] TBASE_MASK = ~(XLEN'(2));
   localparam logic [XLEN-1:0] RET_MASK   = ~(XLEN'(1));
   localparam logic [XLEN-1:0] CAUSE_MASK =
      {1'b1, {(XLEN-1-CAUSE_CODE_W){1'b0}}, {CAUSE_CODE_W{1'b1}}};

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mcsr_file: only a 32-bit register width is supported");
      end
      if (INHIBIT_W <= RET_FREEZE_BIT) begin : g_bad_inh
         $error("mcsr_file: inhibit word too narrow for both freeze bits");
      end
      if (CAUSE_CODE_W < 1 || CAUSE_CODE_W > XLEN - 2) begin : g_bad_cause
         $error("mcsr_file: cause code width out of range");
      end
   endgenerate

   sel_e                 sel;
   logic                 hit;
   logic                 priv_fault;
   logic                 legal;
   logic                 wr_fire;
   logic [XLEN-1:0]      raw_rd;
   logic [XLEN-1:0]      wr_val;
   logic [XLEN-1:0]      pend_view;

   logic [XLEN-1:0]      status_q;
   logic [XLEN-1:0]      ien_q;
   logic [XLEN-1:0]      tbase_q;
   logic [XLEN-1:0]      scratch_q;
   logic [XLEN-1:0]      retaddr_q;
   logic [XLEN-1:0]      cause_q;
   logic [XLEN-1:0]      pend_q;
   logic [INHIBIT_W-1:0] inh_q;

   logic [CNT_W-1:0]     cnt_q [N_CNT];
   logic [CNT_W-1:0]     cycle_q;
   logic [CNT_W-1:0]     instret_q;

   mcsr_decode #(
      .PRIV_W(2)
   ) u_decode (
      .addr       (csr_addr),
      .priv       (priv),
      .sel        (sel),
      .hit        (hit),
      .priv_fault (priv_fault)
   );

   assign legal       = hit && !priv_fault;
   assign csr_illegal = (csr_ren || csr_wen) && !legal;
   assign wr_fire     = csr_wen && legal;

   assign pend_view = pend_q
                    | (XLEN'(irq_soft)  << SOFT_LINE_BIT)
                    | (XLEN'(irq_timer) << TIMER_LINE_BIT)
                    | (XLEN'(irq_ext)   << EXT_LINE_BIT);

   always_comb begin
      unique case (sel)
         SEL_STATUS:  raw_rd = status_q;
         SEL_ISA:     raw_rd = ISA_WORD;
         SEL_IEN:     raw_rd = ien_q;
         SEL_TBASE:   raw_rd = tbase_q;
         SEL_INHIBIT: raw_rd = XLEN'(inh_q);
         SEL_SCRATCH: raw_rd = scratch_q;
         SEL_RETADDR: raw_rd = retaddr_q;
         SEL_CAUSE:   raw_rd = cause_q;
         SEL_PEND:    raw_rd = pend_view;
         SEL_CYC_LO:  raw_rd = cycle_q[XLEN-1:0];
         SEL_CYC_HI:  raw_rd = cycle_q[CNT_W-1:XLEN];
         SEL_RET_LO:  raw_rd = instret_q[XLEN-1:0];
         SEL_RET_HI:  raw_rd = instret_q[CNT_W-1:XLEN];
         SEL_VENDOR:  raw_rd = VENDOR_WORD;
         SEL_ARCH:    raw_rd = ARCH_WORD;
         SEL_IMPL:    raw_rd = IMPL_WORD;
         SEL_CFGPTR:  raw_rd = CFGPTR_WORD;
         default:     raw_rd = '0;
      endcase
   end

   assign csr_rdata = legal ? raw_rd : '0;

   always_comb begin
      unique case (op_e'(csr_op))
         OP_SET:   wr_val = raw_rd | csr_wdata;
         OP_CLEAR: wr_val = raw_rd & ~csr_wdata;
         default:  wr_val = csr_wdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q  <= '0;
         ien_q     <= '0;
         tbase_q   <= '0;
         scratch_q <= '0;
         retaddr_q <= '0;
         cause_q   <= '0;
         pend_q    <= '0;
         inh_q     <= '0;
      end else if (wr_fire) begin
         unique case (sel)
            SEL_STATUS:  status_q  <= wr_val;
            SEL_IEN:     ien_q     <= wr_val;
            SEL_TBASE:   tbase_q   <= wr_val & TBASE_MASK;
            SEL_SCRATCH: scratch_q <= wr_val;
            SEL_RETADDR: retaddr_q <= wr_val & RET_MASK;
            SEL_CAUSE:   cause_q   <= wr_val & CAUSE_MASK;
            SEL_PEND:    pend_q    <= wr_val;
            SEL_INHIBIT: inh_q     <= wr_val[INHIBIT_W-1:0];
            default:     ;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < N_CNT; g++) begin : g_ctr
         localparam sel_e LO_SEL     = (g == 0) ? SEL_CYC_LO : SEL_RET_LO;
         localparam sel_e HI_SEL     = (g == 0) ? SEL_CYC_HI : SEL_RET_HI;
         localparam int   FREEZE_BIT = (g == 0) ? CYC_FREEZE_BIT : RET_FREEZE_BIT;

         mcsr_counter #(
            .HALF_W(XLEN)
         ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (!inh_q[FREEZE_BIT]),
            .wr_lo (wr_fire && (sel == LO_SEL)),
            .wr_hi (wr_fire && (sel == HI_SEL)),
            .wdata (wr_val),
            .count (cnt_q[g])
         );
      end
   endgenerate

   assign cycle_q   = cnt_q[0];
   assign instret_q = cnt_q[1];

endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk
   import mcsr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int INHIBIT_W = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     csr_addr,
   input logic                  csr_ren,
   input logic                  csr_wen,
   input logic [1:0]            priv,
   input logic                  irq_timer,
   input logic [XLEN-1:0]       csr_rdata,
   input logic                  csr_illegal,
   input logic                  wr_fire,
   input logic [2*XLEN-1:0]     cycle_q,
   input logic [2*XLEN-1:0]     instret_q,
   input logic [INHIBIT_W-1:0]  inh_q
);

   logic cyc_wr;
   logic ret_wr;

   assign cyc_wr = wr_fire && (csr_addr == A_CYC_LO || csr_addr == A_CYC_HI);
   assign ret_wr = wr_fire && (csr_addr == A_RET_LO || csr_addr == A_RET_HI);

   // R1: privilege above the caller's level faults
   p_priv_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_ren || csr_wen) && (csr_addr[9:8] > priv)) |-> (csr_illegal && csr_rdata == '0));

   // R6: free-running cycle count
   p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!inh_q[CYC_FREEZE_BIT] && !cyc_wr) |=> (cycle_q == $past(cycle_q) + 64'd1));

   // R7: frozen counters hold
   p_cycle_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_q[CYC_FREEZE_BIT] && !cyc_wr) |=> $stable(cycle_q));

   p_instret_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_q[RET_FREEZE_BIT] && !ret_wr) |=> $stable(instret_q));

   // R8: high half still receives the carry while the low half is written
   p_half_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && csr_addr == A_CYC_LO && !inh_q[CYC_FREEZE_BIT]) |=>
      (cycle_q[2*XLEN-1:XLEN] ==
       $past(cycle_q[2*XLEN-1:XLEN]) + XLEN'($past(cycle_q[XLEN-1:0]) == '1)));

   // R10: trap value always reads zero
   p_tvalue_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == A_TVALUE) |-> (csr_rdata == '0));

   // R5: cause read shows only the kept bits
   p_cause_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == A_CAUSE) |-> (csr_rdata[30:4] == '0));

   // R9: timer line visible in the pending word
   p_timer_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_timer && csr_addr == A_PEND && priv == 2'd3) |-> csr_rdata[TIMER_LINE_BIT]);

endmodule

bind mcsr_file mcsr_file_chk #(
   .XLEN      (XLEN),
   .INHIBIT_W (INHIBIT_W)
) u_chk (.*);

// File: tb/tb_mcsr_file.sv
module tb_mcsr_file;

   localparam logic [31:0] VEND = 32'h1357_9BDF;
   localparam logic [31:0] ARCH = 32'h0000_0042;
   localparam logic [31:0] IMPL = 32'hCAFE_0001;
   localparam logic [31:0] ISAW = 32'h4000_1104;
   localparam logic [31:0] CFGP = 32'h0000_4400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic        csr_ren = 1'b0;
   logic        csr_wen = 1'b0;
   logic [1:0]  csr_op = '0;
   logic [31:0] csr_wdata = '0;
   logic [1:0]  priv = 2'd3;
   logic        irq_soft = 1'b0;
   logic        irq_timer = 1'b0;
   logic        irq_ext = 1'b0;
   logic [31:0] csr_rdata;
   logic        csr_illegal;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // behavioural model state
   logic [31:0]    m_status, m_ien, m_tbase, m_scr, m_ret, m_cause, m_pend;
   logic [2:0]     m_inh;
   longint unsigned m_cyc, m_ins;

   always #10 clk = ~clk;

   mcsr_file #(
      .VENDOR_WORD (VEND),
      .ARCH_WORD   (ARCH),
      .IMPL_WORD   (IMPL),
      .ISA_WORD    (ISAW),
      .CFGPTR_WORD (CFGP)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .csr_addr    (csr_addr),
      .csr_ren     (csr_ren),
      .csr_wen     (csr_wen),
      .csr_op      (csr_op),
      .csr_wdata   (csr_wdata),
      .priv        (priv),
      .irq_soft    (irq_soft),
      .irq_timer   (irq_timer),
      .irq_ext     (irq_ext),
      .csr_rdata   (csr_rdata),
      .csr_illegal (csr_illegal)
   );

   function automatic void model_read(input logic [11:0] a, input logic [1:0] pv,
                                      output bit ok, output logic [31:0] v);
      bit dec = 1'b1;
      v = '0;
      case (a)
         12'h300: v = m_status;
         12'h301: v = ISAW;
         12'h304: v = m_ien;
         12'h305: v = m_tbase;
         12'h320: v = {29'd0, m_inh};
         12'h340: v = m_scr;
         12'h341: v = m_ret;
         12'h342: v = m_cause;
         12'h343: v = '0;
         12'h344: v = m_pend | ({31'd0, irq_soft} << 3) | ({31'd0, irq_timer} << 7)
                             | ({31'd0, irq_ext} << 11);
         12'hB00: v = m_cyc[31:0];
         12'hB80: v = m_cyc[63:32];
         12'hB02: v = m_ins[31:0];
         12'hB82: v = m_ins[63:32];
         12'hF11: v = VEND;
         12'hF12: v = ARCH;
         12'hF13: v = IMPL;
         12'hF14: v = '0;
         12'hF15: v = CFGP;
         default: dec = 1'b0;
      endcase
      ok = dec && (a[9:8] <= pv);
      if (!ok) v = '0;
   endfunction

   task automatic model_clock(input logic [11:0] a, input bit w, input logic [1:0] op,
                              input logic [31:0] d, input logic [1:0] pv);
      bit ok;
      logic [31:0] old, nv;
      longint unsigned nc, ni;
      model_read(a, pv, ok, old);
      case (op)
         2'b01:   nv = old | d;
         2'b10:   nv = old & ~d;
         default: nv = d;
      endcase
      nc = m_inh[0] ? m_cyc : m_cyc + 64'd1;
      ni = m_inh[2] ? m_ins : m_ins + 64'd1;
      if (w && ok) begin
         case (a)
            12'hB00: nc[31:0]  = nv;
            12'hB80: nc[63:32] = nv;
            12'hB02: ni[31:0]  = nv;
            12'hB82: ni[63:32] = nv;
            12'h300: m_status = nv;
            12'h304: m_ien    = nv;
            12'h305: m_tbase  = nv & 32'hFFFF_FFFD;
            12'h340: m_scr    = nv;
            12'h341: m_ret    = nv & 32'hFFFF_FFFE;
            12'h342: m_cause  = nv & 32'h8000_000F;
            12'h344: m_pend   = nv;
            12'h320: m_inh    = nv[2:0];
            default: ;
         endcase
      end
      m_cyc = nc;
      m_ins = ni;
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one clock: drive, compare outputs against model, clock model
   task automatic step(input string req, input logic [11:0] a, input bit r, input bit w,
                       input logic [1:0] op, input logic [31:0] d, input logic [1:0] pv);
      bit ok;
      logic [31:0] ev;
      csr_addr = a; csr_ren = r; csr_wen = w; csr_op = op; csr_wdata = d; priv = pv;
      #2;
      model_read(a, pv, ok, ev);
      check(req, "rdata", csr_rdata, ev);
      check(req, "illegal", {31'd0, csr_illegal}, {31'd0, (r || w) && !ok});
      @(posedge clk);
      model_clock(a, w, op, d, pv);
      @(negedge clk);
   endtask

   task automatic rd(input string req, input logic [11:0] a);
      step(req, a, 1'b1, 1'b0, 2'b00, '0, 2'd3);
   endtask

   task automatic wr(input string req, input logic [11:0] a, input logic [1:0] op,
                     input logic [31:0] d);
      step(req, a, 1'b0, 1'b1, op, d, 2'd3);
   endtask

   initial begin
      m_status = '0; m_ien = '0; m_tbase = '0; m_scr = '0; m_ret = '0;
      m_cause = '0; m_pend = '0; m_inh = '0; m_cyc = 0; m_ins = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset values
      rd("R11", 12'h300); rd("R11", 12'hB00); rd("R11", 12'h342);
      rd("R11", 12'h320); rd("R11", 12'h305);

      // R3: plain writes and read back
      wr("R3", 12'h340, 2'b00, 32'hA5A5_5A5A); rd("R3", 12'h340);
      wr("R3", 12'h300, 2'b11, 32'h0000_1888); rd("R3", 12'h300);

      // R4: set and clear
      wr("R4", 12'h304, 2'b00, 32'h0000_0F0F);
      wr("R4", 12'h304, 2'b01, 32'h0000_8080); rd("R4", 12'h304);
      wr("R4", 12'h304, 2'b10, 32'h0000_000C); rd("R4", 12'h304);

      // R5: masks
      wr("R5", 12'h305, 2'b00, 32'hFFFF_FFFF); rd("R5", 12'h305);
      wr("R5", 12'h341, 2'b00, 32'hFFFF_FFFF); rd("R5", 12'h341);
      wr("R5", 12'h342, 2'b00, 32'hFFFF_FFFF); rd("R5", 12'h342);
      wr("R5", 12'h320, 2'b00, 32'hFFFF_FFF8); rd("R5", 12'h320);

      // R6: counting
      for (int i = 0; i < 4; i++) rd("R6", 12'hB00);
      for (int i = 0; i < 3; i++) rd("R6", 12'hB02);

      // R8: low-half write with carry into high half
      wr("R8", 12'hB00, 2'b00, 32'hFFFF_FFFE);
      for (int i = 0; i < 3; i++) rd("R8", 12'hB80);
      rd("R8", 12'hB00);
      wr("R8", 12'hB80, 2'b00, 32'h0000_0007);
      rd("R8", 12'hB00); rd("R8", 12'hB80);
      wr("R8", 12'hB82, 2'b00, 32'h0000_0011); rd("R8", 12'hB02); rd("R8", 12'hB82);
      wr("R8", 12'hB02, 2'b01, 32'h8000_0000); rd("R8", 12'hB02);

      // R7: freezing
      wr("R7", 12'h320, 2'b00, 32'h0000_0001);
      for (int i = 0; i < 3; i++) rd("R7", 12'hB00);
      rd("R7", 12'hB02);
      wr("R7", 12'h320, 2'b00, 32'h0000_0004);
      rd("R7", 12'hB02); rd("R7", 12'hB02); rd("R7", 12'hB00);
      wr("R7", 12'h320, 2'b10, 32'h0000_0007);
      rd("R7", 12'hB02); rd("R7", 12'hB00);

      // R9: pending word with live lines
      wr("R9", 12'h344, 2'b00, 32'h0000_0002);
      irq_soft = 1'b1; rd("R9", 12'h344);
      irq_soft = 1'b0; irq_timer = 1'b1; rd("R9", 12'h344);
      irq_timer = 1'b0; irq_ext = 1'b1; rd("R9", 12'h344);
      irq_soft = 1'b1; irq_timer = 1'b1;
      wr("R9", 12'h344, 2'b01, 32'h0000_0000);
      irq_soft = 1'b0; irq_timer = 1'b0; irq_ext = 1'b0;
      rd("R9", 12'h344);

      // R10: identification and constant-zero words
      rd("R10", 12'hF11); rd("R10", 12'hF12); rd("R10", 12'hF13);
      rd("R10", 12'hF14); rd("R10", 12'hF15); rd("R10", 12'h301);
      wr("R10", 12'hF11, 2'b00, 32'h0BAD_F00D); rd("R10", 12'hF11);
      wr("R10", 12'h343, 2'b00, 32'hFFFF_FFFF); rd("R10", 12'h343);
      wr("R10", 12'hF14, 2'b01, 32'h0000_00FF); rd("R10", 12'hF14);

      // R1: privilege faults
      step("R1", 12'h340, 1'b1, 1'b0, 2'b00, '0, 2'd0);
      step("R1", 12'h340, 1'b0, 1'b1, 2'b00, 32'h1111_2222, 2'd0);
      step("R1", 12'hB00, 1'b1, 1'b1, 2'b00, 32'h0, 2'd1);
      rd("R1", 12'h340); rd("R1", 12'hB00);

      // R2: undecoded addresses
      rd("R2", 12'h7C0); rd("R2", 12'hC00); rd("R2", 12'h3A0);
      wr("R2", 12'h345, 2'b00, 32'hFFFF_FFFF);
      step("R2", 12'h7C0, 1'b0, 1'b0, 2'b00, '0, 2'd3);
      rd("R2", 12'h340);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule